// File: doc/BRIEF.md
# Timer DMA Burst Write Redirector

This block sits on the register-write path of a timer. A DMA engine writes only to one fixed word address, the burst window port. The block steers each of those writes onto a run of consecutive timer registers. Software programs a start word offset and a run length into a control register, and sets an enable bit. From then on, every timer update event raises a DMA request. Each write the DMA makes to the window port lands on the next register in the run. When the write that completes the run has been accepted, the request drops and the block waits for the next update event.

Writes to any other timer address pass through unchanged. Writes to the control and enable registers stay inside the block. All writes reach the timer register bank through one registered write port, one clock after the bus write. Timer data is 16 bits wide and is written whole into the target register. Reset is asynchronous and active-low, and its release is synchronised inside the block.

Top module: `tmr_burst_redirect`

## Requirements
- R1: After reset, `dma_req` and `reg_we` are low, the enable bit is clear and the start offset is 0. An update event then raises no request, and a window-port write lands on register 0.
- R2: Control register at word 20. Bits [4:0] hold the start word offset, and bits [12:8] hold the run length minus one. Enable register at word 21, where bit 0 enables the update request. Writes to either register are not forwarded to the register port.
- R3: A one-cycle `upd_evt` with the enable bit set raises `dma_req` one clock later. With the enable bit clear, `dma_req` stays low.
- R4: The write with index k to the window port (word 22) during a run appears one clock later on `reg_we`, `reg_waddr` = start + k and `reg_wdata` = the written data. The index k counts from 0.
- R5: `dma_req` stays high until the window-port write with index equal to the programmed length field is accepted. It is low from the next clock, and the index returns to 0.
- R6: Each new update event after a run starts again at the start offset. Six words over two events land on start, start+1, start+2 twice.
- R7: An update event that arrives while a run is in progress is ignored. The request stays high and the index is not reset.
- R8: A window-port write while no run is active is forwarded to the start register and does not advance the index.
- R9: A redirected target at or above word 20 is not written (`reg_we` stays low). It still counts toward the run length.
- R10: A write to an ordinary timer address below 20 is forwarded unchanged one clock later. A write to an unused address at or above 23 produces no register write.
- R11: A length field of 0 gives a one-write run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_evt | input | 1 | Timer update event, one-cycle pulse |
| bus_we | input | 1 | Bus write strobe |
| bus_addr | input | 5 | Bus word address |
| bus_wdata | input | 16 | Bus write data |
| dma_req | output | 1 | DMA request to the controller |
| reg_we | output | 1 | Write strobe to the timer register bank |
| reg_waddr | output | 5 | Word address of the timer register written |
| reg_wdata | output | 16 | Data written to the timer register |

## Verification
The assertions take for granted that the control register is not rewritten while a run is in progress. A run length that shrinks below the current index would let the index walk past the end of the run. They also assume `upd_evt` is a single-cycle pulse. The directed stimulus rewrites the control and enable registers only while `dma_req` is low. It drives every update event for exactly one clock, and issues bus writes and update events in separate cycles.

// File: rtl/tbr_pkg.sv
package tbr_pkg;

  // Run sequencer state
  typedef enum logic [0:0] {
    SEQ_IDLE  = 1'b0,
    SEQ_BURST = 1'b1
  } seq_state_e;

  // Classification of the current bus write
  typedef enum logic [2:0] {
    HIT_NONE  = 3'd0,
    HIT_PLAIN = 3'd1,
    HIT_CTRL  = 3'd2,
    HIT_ENA   = 3'd3,
    HIT_WIN   = 3'd4
  } hit_e;

endpackage

// File: rtl/tbr_cfg.sv
module tbr_cfg
  import tbr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 5,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned LEN_W     = 5,
  parameter int unsigned LEN_LSB   = 8,
  parameter int unsigned CTRL_ADDR = 20,
  parameter int unsigned ENA_ADDR  = 21,
  parameter int unsigned WIN_ADDR  = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output hit_e              hit,
  output logic [ADDR_W-1:0] base_q,
  output logic [LEN_W-1:0]  len_m1_q,
  output logic              ude_q
);

  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] ENA_A  = ADDR_W'(ENA_ADDR);
  localparam logic [ADDR_W-1:0] WIN_A  = ADDR_W'(WIN_ADDR);

  logic [ADDR_W-1:0] base_d;
  logic [LEN_W-1:0]  len_m1_d;
  logic              ude_d;
  logic              ctrl_en;
  logic              ena_en;
  logic              unused_wdata;

  // Address decode of the incoming write
  always_comb begin
    hit = HIT_NONE;
    if (bus_we) begin
      unique case (bus_addr)
        CTRL_A:  hit = HIT_CTRL;
        ENA_A:   hit = HIT_ENA;
        WIN_A:   hit = HIT_WIN;
        default: hit = HIT_PLAIN;
      endcase
    end
  end

  assign ctrl_en = (hit == HIT_CTRL);
  assign ena_en  = (hit == HIT_ENA);

  // Next-state values for the configuration fields
  always_comb begin
    base_d   = bus_wdata[ADDR_W-1:0];
    len_m1_d = bus_wdata[LEN_LSB +: LEN_W];
    ude_d    = bus_wdata[0];
  end

  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q   <= '0;
      len_m1_q <= '0;
    end else if (ctrl_en) begin
      base_q   <= base_d;
      len_m1_q <= len_m1_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ude_q <= 1'b0;
    end else if (ena_en) begin
      ude_q <= ude_d;
    end
  end

endmodule

// File: rtl/tbr_seq.sv
module tbr_seq
  import tbr_pkg::*;
#(
  parameter int unsigned LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_evt,
  input  logic             ude,
  input  logic             win_wr,
  input  logic [LEN_W-1:0] len_m1,
  output logic             busy,
  output logic [LEN_W-1:0] idx_q
);

  seq_state_e       state_q;
  seq_state_e       state_d;
  logic [LEN_W-1:0] idx_d;
  logic             idx_en;
  logic             last_wr;

  assign last_wr = win_wr && (idx_q == len_m1);

  // Next-state logic: update events only count while idle
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    idx_en  = 1'b0;
    unique case (state_q)
      SEQ_IDLE: begin
        if (upd_evt && ude) begin
          state_d = SEQ_BURST;
          idx_d   = '0;
          idx_en  = 1'b1;
        end
      end
      SEQ_BURST: begin
        if (last_wr) begin
          state_d = SEQ_IDLE;
          idx_d   = '0;
          idx_en  = 1'b1;
        end else if (win_wr) begin
          idx_d   = idx_q + 1'b1;
          idx_en  = 1'b1;
        end
      end
      default: begin
        state_d = SEQ_IDLE;
        idx_d   = '0;
        idx_en  = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0;
    end else if (idx_en) begin
      idx_q <= idx_d;
    end
  end

  assign busy = (state_q == SEQ_BURST);

endmodule

// File: rtl/tbr_route.sv
module tbr_route
  import tbr_pkg::*;
#(
  parameter int unsigned NUM_REGS = 20,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned LEN_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  hit_e              hit,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  idx,
  output logic              reg_we_q,
  output logic [ADDR_W-1:0] reg_addr_q,
  output logic [DATA_W-1:0] reg_data_q
);

  localparam int unsigned SUM_W = ((LEN_W > ADDR_W) ? LEN_W : ADDR_W) + 1;
  localparam logic [SUM_W-1:0] LIMIT = SUM_W'(NUM_REGS);

  logic [SUM_W-1:0]  target;
  logic [SUM_W-1:0]  plain_wide;
  logic              we_d;
  logic [ADDR_W-1:0] addr_d;

  // Window target: start offset plus run index, kept wide to see overflow
  assign target     = SUM_W'(base) + SUM_W'(idx);
  assign plain_wide = SUM_W'(bus_addr);

  always_comb begin
    we_d   = 1'b0;
    addr_d = bus_addr;
    unique case (hit)
      HIT_WIN: begin
        addr_d = target[ADDR_W-1:0];
        we_d   = (target < LIMIT);
      end
      HIT_PLAIN: begin
        we_d   = (plain_wide < LIMIT);
      end
      default: begin
        we_d   = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_we_q <= 1'b0;
    end else begin
      reg_we_q <= we_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_addr_q <= '0;
      reg_data_q <= '0;
    end else if (we_d) begin
      reg_addr_q <= addr_d;
      reg_data_q <= bus_wdata;
    end
  end

endmodule

// File: rtl/tmr_burst_redirect.sv
module tmr_burst_redirect
  import tbr_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 20,
  parameter int unsigned ADDR_W      = 5,
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned LEN_W       = 5,
  parameter int unsigned LEN_LSB     = 8,
  parameter int unsigned CTRL_ADDR   = 20,
  parameter int unsigned ENA_ADDR    = 21,
  parameter int unsigned WIN_ADDR    = 22,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_evt,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic              dma_req,
  output logic              reg_we,
  output logic [ADDR_W-1:0] reg_waddr,
  output logic [DATA_W-1:0] reg_wdata
);

  logic              rst_n_s;
  hit_e              hit;
  logic [ADDR_W-1:0] base_q;
  logic [LEN_W-1:0]  len_m1_q;
  logic              ude_q;
  logic [LEN_W-1:0]  idx_q;
  logic              win_wr;

  // Reset: asserted asynchronously, released on the clock
  generate
    if (SYNC_STAGES < 2) begin : g_sync_one
      logic sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= 1'b0;
        else        sync_q <= 1'b1;
      end
      assign rst_n_s = sync_q;
    end else begin : g_sync_chain
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], 1'b1};
      end
      assign rst_n_s = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  tbr_cfg #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .LEN_W    (LEN_W),
    .LEN_LSB  (LEN_LSB),
    .CTRL_ADDR(CTRL_ADDR),
    .ENA_ADDR (ENA_ADDR),
    .WIN_ADDR (WIN_ADDR)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .hit      (hit),
    .base_q   (base_q),
    .len_m1_q (len_m1_q),
    .ude_q    (ude_q)
  );

  assign win_wr = (hit == HIT_WIN);

  tbr_seq #(
    .LEN_W(LEN_W)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .upd_evt(upd_evt),
    .ude    (ude_q),
    .win_wr (win_wr),
    .len_m1 (len_m1_q),
    .busy   (dma_req),
    .idx_q  (idx_q)
  );

  tbr_route #(
    .NUM_REGS(NUM_REGS),
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .LEN_W   (LEN_W)
  ) u_route (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .hit       (hit),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .base      (base_q),
    .idx       (idx_q),
    .reg_we_q  (reg_we),
    .reg_addr_q(reg_waddr),
    .reg_data_q(reg_wdata)
  );

endmodule

// File: rtl/tbr_chk.sv
module tbr_chk #(
  parameter int unsigned NUM_REGS = 20,
  parameter int unsigned ADDR_W   = 5,
  parameter int unsigned LEN_W    = 5,
  parameter int unsigned WIN_ADDR = 22
) (
  input logic              clk,
  input logic              rst_n,
  input logic              upd_evt,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              dma_req,
  input logic              reg_we,
  input logic [ADDR_W-1:0] reg_waddr,
  input logic              ude,
  input logic [ADDR_W-1:0] base,
  input logic [LEN_W-1:0]  len_m1,
  input logic [LEN_W-1:0]  idx
);

  localparam int unsigned SUM_W = ((LEN_W > ADDR_W) ? LEN_W : ADDR_W) + 1;
  localparam logic [SUM_W-1:0]  LIMIT = SUM_W'(NUM_REGS);
  localparam logic [ADDR_W-1:0] WIN_A = ADDR_W'(WIN_ADDR);

  logic             port_wr;
  logic [SUM_W-1:0] slot;

  assign port_wr = bus_we && (bus_addr == WIN_A);
  assign slot    = SUM_W'(base) + SUM_W'(idx);

  assert_req_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dma_req) |-> $past(upd_evt && ude));

  assert_req_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_req && !ude) |=> !dma_req);

  assert_slot_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && port_wr && (slot < LIMIT)) |=> (reg_we && (reg_waddr == $past(slot[ADDR_W-1:0]))));

  assert_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && port_wr && (idx == len_m1)) |=> (!dma_req && (idx == '0)));

  assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !port_wr) |=> (dma_req && $stable(idx)));

  assert_idle_idx_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dma_req |-> (idx == '0));

  assert_in_bank_R9: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |-> (SUM_W'(reg_waddr) < LIMIT));

endmodule

bind tmr_burst_redirect tbr_chk #(
  .NUM_REGS(NUM_REGS),
  .ADDR_W  (ADDR_W),
  .LEN_W   (LEN_W),
  .WIN_ADDR(WIN_ADDR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_s),
  .upd_evt  (upd_evt),
  .bus_we   (bus_we),
  .bus_addr (bus_addr),
  .dma_req  (dma_req),
  .reg_we   (reg_we),
  .reg_waddr(reg_waddr),
  .ude      (ude_q),
  .base     (base_q),
  .len_m1   (len_m1_q),
  .idx      (idx_q)
);

// File: tb/sim_tmr_burst_redirect.sv
module sim_tmr_burst_redirect;

  localparam int unsigned CTRL = 20;
  localparam int unsigned ENA  = 21;
  localparam int unsigned WIN  = 22;

  logic        clk;
  logic        rst_n;
  logic        upd_evt;
  logic        bus_we;
  logic [4:0]  bus_addr;
  logic [15:0] bus_wdata;
  logic        dma_req;
  logic        reg_we;
  logic [4:0]  reg_waddr;
  logic [15:0] reg_wdata;

  int n_chk;
  int n_bad;

  tmr_burst_redirect u0 (
    .clk      (clk),
    .rst_n    (rst_n),
    .upd_evt  (upd_evt),
    .bus_we   (bus_we),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .dma_req  (dma_req),
    .reg_we   (reg_we),
    .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Bus write; checks the register port one clock later
  task automatic wr(input int addr, input int data, input int exp_we,
                    input int exp_addr, input string tag);
    bus_we    = 1'b1;
    bus_addr  = 5'(addr);
    bus_wdata = 16'(data);
    @(negedge clk);
    bus_we    = 1'b0;
    chk({tag, " we"}, int'(reg_we), exp_we);
    if (exp_we != 0) begin
      chk({tag, " addr"}, int'(reg_waddr), exp_addr);
      chk({tag, " data"}, int'(reg_wdata), data);
    end
  endtask

  task automatic upd(input int exp_req, input string tag);
    upd_evt = 1'b1;
    @(negedge clk);
    upd_evt = 1'b0;
    chk({tag, " req"}, int'(dma_req), exp_req);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 req in reset", int'(dma_req), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 req after reset", int'(dma_req), 0);
    chk("R1 we after reset", int'(reg_we), 0);
    upd(0, "R1 enable clear");
    wr(WIN, 16'h1111, 1, 0, "R1 start offset zero");
  endtask

  task automatic t_config;
    wr(CTRL, 16'h020E, 0, 0, "R2 ctrl not forwarded");
    wr(ENA, 16'h0001, 0, 0, "R2 enable not forwarded");
  endtask

  task automatic t_basic;
    upd(1, "R3 request raised");
    wr(WIN, 16'hA001, 1, 14, "R4 first");
    chk("R5 held mid-run", int'(dma_req), 1);
    wr(WIN, 16'hA002, 1, 15, "R4 second");
    wr(WIN, 16'hA003, 1, 16, "R4 third");
    chk("R5 dropped after last", int'(dma_req), 0);
  endtask

  task automatic t_two_events;
    for (int ev = 0; ev < 2; ev++) begin
      upd(1, "R6 event");
      for (int k = 0; k < 3; k++)
        wr(WIN, 16'hB000 + ev * 3 + k, 1, 14 + k, "R6 restart");
      chk("R6 dropped", int'(dma_req), 0);
    end
  endtask

  task automatic t_mid_event;
    upd(1, "R7 start");
    wr(WIN, 16'hC001, 1, 14, "R7 first");
    upd(1, "R7 ignored event");
    wr(WIN, 16'hC002, 1, 15, "R7 index kept");
    wr(WIN, 16'hC003, 1, 16, "R7 third");
    chk("R7 dropped", int'(dma_req), 0);
  endtask

  task automatic t_idle_write;
    wr(WIN, 16'hD001, 1, 14, "R8 idle to start");
    wr(WIN, 16'hD002, 1, 14, "R8 no advance");
    chk("R8 no request", int'(dma_req), 0);
    upd(1, "R8 run after idle");
    wr(WIN, 16'hD003, 1, 14, "R8 index zero");
    wr(WIN, 16'hD004, 1, 15, "R8 second");
    wr(WIN, 16'hD005, 1, 16, "R8 third");
  endtask

  task automatic t_disable;
    wr(ENA, 16'h0000, 0, 0, "R3 disable");
    upd(0, "R3 gated off");
    wr(ENA, 16'h0001, 0, 0, "R3 re-enable");
  endtask

  task automatic t_range;
    wr(CTRL, 16'h0312, 0, 0, "R9 config");
    upd(1, "R9 start");
    wr(WIN, 16'hE001, 1, 18, "R9 in bank");
    wr(WIN, 16'hE002, 1, 19, "R9 last in bank");
    wr(WIN, 16'hE003, 0, 0, "R9 suppressed 20");
    chk("R9 still running", int'(dma_req), 1);
    wr(WIN, 16'hE004, 0, 0, "R9 suppressed 21");
    chk("R9 run complete", int'(dma_req), 0);
  endtask

  task automatic t_single;
    wr(CTRL, 16'h0005, 0, 0, "R11 config");
    upd(1, "R11 start");
    wr(WIN, 16'hF001, 1, 5, "R11 only write");
    chk("R11 dropped", int'(dma_req), 0);
  endtask

  task automatic t_plain;
    wr(3, 16'h1234, 1, 3, "R10 plain forward");
    wr(19, 16'h4321, 1, 19, "R10 top of bank");
    wr(25, 16'h5555, 0, 0, "R10 unused address");
  endtask

  initial begin
    n_chk     = 0;
    n_bad     = 0;
    rst_n     = 1'b0;
    upd_evt   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = '0;
    bus_wdata = '0;
    @(negedge clk);
    t_reset();
    t_config();
    t_basic();
    t_two_events();
    t_mid_event();
    t_idle_write();
    t_disable();
    t_range();
    t_single();
    t_plain();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule